// File: doc/BRIEF.md
# Counter-Based Microsequencer for a Multicycle Controller

This block sequences the control of a multicycle processor datapath. Rather than computing a next state for every state with dedicated logic, it holds a 4-bit state register. A per-state control store supplies two things: a 16-bit datapath control word and a 2-bit sequencing mode. The mode picks where the sequence goes next. It can fall back to state 0, jump through one of two opcode-indexed dispatch tables, or step to the current state plus one. Every state lasts exactly one clock cycle.

The datapath supplies the 6-bit opcode of the instruction held in its instruction register. It takes the current state and the control word, which depends only on the state register and is valid in the same cycle. No data stream passes through the block, so it has no valid/ready handshake. All pins are plain control pins.

The opcode is sampled only on the clock edge that leaves state 1 or state 2, and it must be stable in those cycles. There is no back-pressure. The sequence advances on every edge while reset is low.

Top module: `useq_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, `state` is 0 after that edge, whatever state the sequence was in.
- R2: From states 0, 3 and 6 the next state is the current state plus one.
- R3: From states 4, 5, 7, 8 and 9 the next state is 0, whatever the opcode.
- R4: From state 1 the next state depends on the opcode:
  - opcode 0 (register-register) goes to 6.
  - opcode 2 (jump) goes to 9.
  - opcode 4 (branch-if-equal) goes to 8.
  - opcode 35 (load) and opcode 43 (store) go to 2.
- R5: From state 2, opcode 35 goes to 3 and opcode 43 goes to 5.
- R6: An opcode not listed for the table in use sends the sequence to state 0. This applies to any opcode other than 0, 2, 4, 35 and 43 in state 1, and to any opcode other than 35 and 43 in state 2.
- R7: `ctrl` is a function of `state` alone and is valid in the same cycle. Its bits are:
  - bit 15: memory read; bit 14: memory write; bit 13: instruction register load.
  - bit 12: unconditional PC write; bit 11: conditional PC write; bit 10: address from ALU result.
  - bit 9: register write; bit 8: write-back from memory data; bit 7: destination is rd.
  - bit 6: ALU operand A from register.
  - bits 5:4: ALU operation (00 add, 01 subtract, 10 function code).
  - bits 3:2: ALU operand B (00 register, 01 constant 4, 10 sign-extended immediate, 11 shifted immediate).
  - bits 1:0: PC source.
  
  The values per state are 0:0xB004, 1:0x000C, 2:0x0048, 3:0x8400, 4:0x0300, 5:0x4400, 6:0x0060, 7:0x0280, 8:0x0851 and 9:0x1002.
- R8: The state changes on every clock edge while reset is low. Each instruction class follows its full path back to state 0:
  - load: 0,1,2,3,4
  - store: 0,1,2,5
  - register-register: 0,1,6,7
  - branch: 0,1,8
  - jump: 0,1,9

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field of the current instruction |
| state | output | 4 | Current sequencer state |
| ctrl | output | 16 | Datapath control word for the current state |

## Verification
`ctrl` is combinational from the state register, so the bench checks it in the same cycle as `state`. A new state is due exactly one rising edge after the cycle whose mode and opcode select it. The effect of reset is also due one edge after `rst` is sampled high. The bench drives and samples on the falling edge. It predicts the next state from the previous expected state and the opcode it drove before the edge. It therefore compares each edge's result half a period after it settles, and never at the edge itself.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int STATE_W = 4;
  localparam int OP_W    = 6;

  typedef enum logic [1:0] {
    AC_ZERO  = 2'd0,
    AC_DISP1 = 2'd1,
    AC_DISP2 = 2'd2,
    AC_INCR  = 2'd3
  } addr_ctl_t;

  typedef struct packed {
    logic       mem_rd;
    logic       mem_wr;
    logic       ir_load;
    logic       pc_load;
    logic       pc_cond;
    logic       addr_sel;
    logic       reg_wr;
    logic       wb_sel;
    logic       dst_sel;
    logic       alu_src_a;
    logic [1:0] alu_op;
    logic [1:0] alu_b;
    logic [1:0] pc_src;
  } ctrl_word_t;

  localparam int CTRL_W = $bits(ctrl_word_t);
endpackage

// File: rtl/useq_ctrl_store.sv
module useq_ctrl_store
  import useq_pkg::*;
(
  input  logic [STATE_W-1:0] state_i,
  output ctrl_word_t         ctrl_o,
  output addr_ctl_t          mode_o
);
  always_comb begin
    ctrl_o = '0;
    mode_o = AC_ZERO;
    case (state_i)
      4'd0: begin
        ctrl_o.mem_rd  = 1'b1;
        ctrl_o.ir_load = 1'b1;
        ctrl_o.pc_load = 1'b1;
        ctrl_o.alu_b   = 2'b01;
        mode_o         = AC_INCR;
      end
      4'd1: begin
        ctrl_o.alu_b = 2'b11;
        mode_o       = AC_DISP1;
      end
      4'd2: begin
        ctrl_o.alu_src_a = 1'b1;
        ctrl_o.alu_b     = 2'b10;
        mode_o           = AC_DISP2;
      end
      4'd3: begin
        ctrl_o.mem_rd   = 1'b1;
        ctrl_o.addr_sel = 1'b1;
        mode_o          = AC_INCR;
      end
      4'd4: begin
        ctrl_o.reg_wr = 1'b1;
        ctrl_o.wb_sel = 1'b1;
      end
      4'd5: begin
        ctrl_o.mem_wr   = 1'b1;
        ctrl_o.addr_sel = 1'b1;
      end
      4'd6: begin
        ctrl_o.alu_src_a = 1'b1;
        ctrl_o.alu_op    = 2'b10;
        mode_o           = AC_INCR;
      end
      4'd7: begin
        ctrl_o.reg_wr  = 1'b1;
        ctrl_o.dst_sel = 1'b1;
      end
      4'd8: begin
        ctrl_o.alu_src_a = 1'b1;
        ctrl_o.alu_op    = 2'b01;
        ctrl_o.pc_cond   = 1'b1;
        ctrl_o.pc_src    = 2'b01;
      end
      4'd9: begin
        ctrl_o.pc_load = 1'b1;
        ctrl_o.pc_src  = 2'b10;
      end
      default: begin
        ctrl_o = '0;
        mode_o = AC_ZERO;
      end
    endcase
  end
endmodule

// File: rtl/useq_dispatch.sv
module useq_dispatch
  import useq_pkg::*;
#(
  parameter int              TABLE_ID = 1,
  parameter logic [OP_W-1:0] OP_RR    = 6'd0,
  parameter logic [OP_W-1:0] OP_JMP   = 6'd2,
  parameter logic [OP_W-1:0] OP_BEQ   = 6'd4,
  parameter logic [OP_W-1:0] OP_LD    = 6'd35,
  parameter logic [OP_W-1:0] OP_ST    = 6'd43
) (
  input  logic [OP_W-1:0]    op_i,
  output logic [STATE_W-1:0] target_o
);
  generate
    if (TABLE_ID == 1) begin : g_first
      always_comb begin
        if      (op_i == OP_RR)                    target_o = 4'd6;
        else if (op_i == OP_JMP)                   target_o = 4'd9;
        else if (op_i == OP_BEQ)                   target_o = 4'd8;
        else if (op_i == OP_LD || op_i == OP_ST)   target_o = 4'd2;
        else                                       target_o = 4'd0;
      end
    end else begin : g_second
      always_comb begin
        if      (op_i == OP_LD) target_o = 4'd3;
        else if (op_i == OP_ST) target_o = 4'd5;
        else                    target_o = 4'd0;
      end
    end
  endgenerate
endmodule

// File: rtl/useq_next_addr.sv
module useq_next_addr
  import useq_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  addr_ctl_t          mode_i,
  input  logic [STATE_W-1:0] disp1_i,
  input  logic [STATE_W-1:0] disp2_i,
  output logic [STATE_W-1:0] state_o
);
  logic [STATE_W-1:0] nxt;

  always_comb begin
    case (mode_i)
      AC_DISP1: nxt = disp1_i;
      AC_DISP2: nxt = disp2_i;
      AC_INCR:  nxt = state_o + STATE_W'(1);
      default:  nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_o <= '0;
    else     state_o <= nxt;
  end
endmodule

// File: rtl/useq_top.sv
module useq_top
  import useq_pkg::*;
#(
  parameter logic [OP_W-1:0] OP_RR  = 6'd0,
  parameter logic [OP_W-1:0] OP_JMP = 6'd2,
  parameter logic [OP_W-1:0] OP_BEQ = 6'd4,
  parameter logic [OP_W-1:0] OP_LD  = 6'd35,
  parameter logic [OP_W-1:0] OP_ST  = 6'd43
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [OP_W-1:0]    opcode,
  output logic [STATE_W-1:0] state,
  output logic [CTRL_W-1:0]  ctrl
);
  ctrl_word_t         word;
  addr_ctl_t          mode;
  logic [STATE_W-1:0] tgt1, tgt2;

  useq_ctrl_store u_store (.state_i(state), .ctrl_o(word), .mode_o(mode));

  useq_dispatch #(.TABLE_ID(1), .OP_RR(OP_RR), .OP_JMP(OP_JMP), .OP_BEQ(OP_BEQ),
                  .OP_LD(OP_LD), .OP_ST(OP_ST))
    u_disp1 (.op_i(opcode), .target_o(tgt1));

  useq_dispatch #(.TABLE_ID(2), .OP_RR(OP_RR), .OP_JMP(OP_JMP), .OP_BEQ(OP_BEQ),
                  .OP_LD(OP_LD), .OP_ST(OP_ST))
    u_disp2 (.op_i(opcode), .target_o(tgt2));

  useq_next_addr u_next (
    .clk(clk), .rst(rst), .mode_i(mode),
    .disp1_i(tgt1), .disp2_i(tgt2), .state_o(state)
  );

  assign ctrl = word;
endmodule

// File: rtl/useq_checker.sv
module useq_checker
  import useq_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic [OP_W-1:0]    opcode,
  input logic [STATE_W-1:0] state,
  input logic [CTRL_W-1:0]  ctrl
);
  assert_reset_R1: assert property (@(posedge clk) rst |=> state == '0);

  assert_incr_R2: assert property (@(posedge clk) disable iff (rst)
    (state == 4'd0 || state == 4'd3 || state == 4'd6) |=> state == $past(state) + 4'd1);

  assert_return_R3: assert property (@(posedge clk) disable iff (rst)
    (state == 4'd4 || state == 4'd5 || state == 4'd7 || state == 4'd8 || state == 4'd9)
    |=> state == 4'd0);

  assert_jump_R4: assert property (@(posedge clk) disable iff (rst)
    (state == 4'd1 && opcode == 6'd2) |=> state == 4'd9);

  assert_load_R5: assert property (@(posedge clk) disable iff (rst)
    (state == 4'd2 && opcode == 6'd35) |=> state == 4'd3);

  assert_unknown_R6: assert property (@(posedge clk) disable iff (rst)
    (state == 4'd2 && opcode != 6'd35 && opcode != 6'd43) |=> state == 4'd0);

  assert_memexcl_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ctrl[15:14]));

  assert_advance_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(state) || $past(rst) || state != 4'd0 || $past(state) != 4'd0);
endmodule

bind useq_top useq_checker u_useq_checker (
  .clk(clk), .rst(rst), .opcode(opcode), .state(state), .ctrl(ctrl)
);

// File: tb/useq_top_bench.sv
module useq_top_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'd0;
  logic [3:0] state;
  logic [15:0] ctrl;
  int checks = 0;
  int fails  = 0;
  logic [3:0] exp_state;
  bit done = 1'b0;

  always #10 clk = ~clk;

  useq_top u_useq_top (.clk(clk), .rst(rst), .opcode(opcode), .state(state), .ctrl(ctrl));

  function automatic logic [3:0] ref_next(input logic [3:0] s, input logic [5:0] op);
    case (s)
      4'd0: return 4'd1;
      4'd3: return 4'd4;
      4'd6: return 4'd7;
      4'd1: begin
        if (op == 6'd0) return 4'd6;
        if (op == 6'd2) return 4'd9;
        if (op == 6'd4) return 4'd8;
        if (op == 6'd35 || op == 6'd43) return 4'd2;
        return 4'd0;
      end
      4'd2: begin
        if (op == 6'd35) return 4'd3;
        if (op == 6'd43) return 4'd5;
        return 4'd0;
      end
      default: return 4'd0;
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] s, input logic [5:0] op);
    case (s)
      4'd0, 4'd3, 4'd6: return "R2";
      4'd1: return (ref_next(s, op) == 4'd0) ? "R6" : "R4";
      4'd2: return (ref_next(s, op) == 4'd0) ? "R6" : "R5";
      default: return "R3";
    endcase
  endfunction

  function automatic logic [15:0] ref_ctrl(input logic [3:0] s);
    case (s)
      4'd0: return 16'hB004;
      4'd1: return 16'h000C;
      4'd2: return 16'h0048;
      4'd3: return 16'h8400;
      4'd4: return 16'h0300;
      4'd5: return 16'h4400;
      4'd6: return 16'h0060;
      4'd7: return 16'h0280;
      4'd8: return 16'h0851;
      4'd9: return 16'h1002;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // R1: sync reset, checked one edge after rst sampled high
  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1", {12'd0, state}, 16'd0);
    rst = 1'b0;
    exp_state = 4'd0;
  endtask

  // Walk one instruction from state 0 until it returns to 0 (R8 path, R7 word)
  task automatic run_instr(input logic [5:0] op, input int len);
    string r;
    opcode = op;
    for (int i = 0; i < len; i++) begin
      check("R7", ctrl, ref_ctrl(exp_state));
      r = req_of(exp_state, op);
      exp_state = ref_next(exp_state, op);
      @(negedge clk);
      check(r, {12'd0, state}, {12'd0, exp_state});
    end
    check("R8", {12'd0, state}, 16'd0);
  endtask

  task automatic test_load();      run_instr(6'd35, 5); endtask
  task automatic test_store();     run_instr(6'd43, 4); endtask
  task automatic test_rr();        run_instr(6'd0, 4);  endtask
  task automatic test_branch();    run_instr(6'd4, 3);  endtask
  task automatic test_jump();      run_instr(6'd2, 3);  endtask
  task automatic test_unknown1();  run_instr(6'd17, 2); endtask

  // R6: opcode known in table 1 but absent from table 2
  task automatic test_unknown2();
    opcode = 6'd35;
    @(negedge clk); exp_state = 4'd1;
    @(negedge clk); exp_state = 4'd2;
    check("R5", {12'd0, state}, {12'd0, exp_state});
    opcode = 6'd4;
    @(negedge clk);
    check("R6", {12'd0, state}, 16'd0);
    exp_state = 4'd0;
  endtask

  // R1: reset in the middle of a register-register instruction
  task automatic test_mid_reset();
    opcode = 6'd0;
    @(negedge clk);
    @(negedge clk);
    check("R4", {12'd0, state}, 16'd6);
    rst = 1'b1;
    @(negedge clk);
    check("R1", {12'd0, state}, 16'd0);
    check("R1", ctrl, 16'hB004);
    rst = 1'b0;
    exp_state = 4'd0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    do_reset();
    test_load();
    test_store();
    test_rr();
    test_branch();
    test_jump();
    test_unknown1();
    test_unknown2();
    test_mid_reset();
    test_load();
    finish_run();
  end

  initial begin
    #(20 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule